// File: doc/BRIEF.md
# Block-Interleave Thread Switch Controller

This block governs a coarse-grained multithreaded core. One thread at a time runs at full pipeline speed. The block watches event strobes from that thread's pipeline: a data-cache miss, a register read that hits a pending load, an unconditional switch instruction, a conditional switch instruction with its operand, and external signal lines, one per thread. From these it decides when to leave the running thread and which thread runs next. A switch is reported one cycle after the event. In that cycle the block gives the new thread ID, a switch pulse, and a flush pulse that names the old thread, so its in-flight instructions can be discarded.

Each thread has a mode register that enables its own trigger kinds.
- Immediate miss switching leaves the thread at once on a miss.
- Lazy switch-on-use records the missed destination register. The switch happens only when a later instruction reads that register, and only if the fill has not already arrived.
- The instruction triggers cover the unconditional and the conditional switch instructions.
- Signal switching lets a wake-up of a sleeping thread preempt the running thread.
- A service thread parks itself with an explicit switch and sleeps until its signal line pulses.

A thread that has switched out on a miss stays ineligible until the completion for that thread arrives. The successor is the lowest-numbered eligible thread other than the current one. If there is none, the current thread stays. When the current thread is itself blocked, the block reports a stall.

Top module: `mt_switch_ctrl`

## Requirements
- R1: Without an enabled trigger, and with the current thread not blocked, `tid_o` holds its value and `switch_o` stays low. A fill or a wake-up alone does not switch the current thread.
- R2: A miss in a thread whose mode bit 0 (immediate miss) is set causes a switch in the next cycle. The old thread is then ineligible until `fill_i` arrives with its ID.
- R3: With mode bit 2 (instruction triggers) set, `sw_explicit_i` always causes a switch. `sw_cond_i` causes a switch only when `sw_cond_val_i` is 1.
- R4: With mode bit 1 (lazy) set and bit 0 clear, a miss records `miss_reg_i` and does not switch. A later `use_i` with the same `use_reg_i` switches and blocks the thread until its fill. A read of a different register does not switch. A fill that arrives before the read cancels the pending switch.
- R5: A trigger whose mode bit is clear is ignored: no switch, and the thread stays. This covers a miss with bits 0 and 1 both clear, a switch instruction with bit 2 clear, and a wake-up with bit 3 clear.
- R6: `ext_sig_i[k]` makes thread k eligible, and it stays eligible. If the current thread has mode bit 3 (signal switch) set, a wake-up of another sleeping thread switches the current thread out.
- R7: A thread with mode bits 4 (service) and 2 set that executes `sw_explicit_i` goes to sleep. It is not chosen again until its signal line pulses. Thread `SVC_THREAD` starts asleep.
- R8: The next thread is the lowest-index eligible thread other than the current one. If none exists, no switch occurs. While the current thread is blocked and no other thread is eligible, `stall_o` is 1. A fill or a wake-up in that state then switches to the newly eligible thread.
- R9: On a switch, `switch_o` and `flush_o` are high for one cycle, `tid_o` gives the new thread, and `flush_tid_o` gives the thread that was left.
- R10: After reset `tid_o` is 0, `switch_o`, `flush_o` and `stall_o` are 0, and every mode register holds `MODE_RST`.
- R11: `mode_we_i` writes `mode_i` into the mode register of thread `mode_tid_i` only. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_tid_i | input | TID_W | Thread whose mode is written |
| mode_i | input | 5 | Mode: bit0 immediate miss, bit1 lazy, bit2 instructions, bit3 signal, bit4 service |
| miss_i | input | 1 | Data-cache miss in the current thread |
| miss_reg_i | input | REG_W | Destination register of the missed load |
| use_i | input | 1 | Current thread reads a register |
| use_reg_i | input | REG_W | Register being read |
| sw_explicit_i | input | 1 | Unconditional switch instruction |
| sw_cond_i | input | 1 | Conditional switch instruction |
| sw_cond_val_i | input | 1 | Condition operand of the conditional switch |
| fill_i | input | 1 | Miss completion strobe |
| fill_tid_i | input | TID_W | Thread whose miss completed |
| ext_sig_i | input | N_THREADS | Wake-up line per thread |
| tid_o | output | TID_W | Thread now running |
| switch_o | output | 1 | One-cycle switch pulse |
| flush_o | output | 1 | One-cycle flush request for the old thread |
| flush_tid_o | output | TID_W | Thread whose in-flight work is flushed |
| stall_o | output | 1 | Current thread blocked with no successor |

## Verification
The bench goes after the lazy path from three sides. A read of a non-matching register must not switch, or the design compares the wrong field. A matching read must switch, or the use trigger is lost. A read after an early fill must not switch, or the design never clears the pending register. It also runs a case where every other thread is waiting or asleep. A design that ignores eligibility would switch into a blocked thread, and one that drops the stall would let a stuck thread run on. A fill that arrives during that stall must switch at once. A wrong priority order or a lost service wake-up shows up as a wrong `tid_o` after the explicit switches.

// File: rtl/mt_switch_pkg.sv
package mt_switch_pkg;
  typedef struct packed {
    logic svc;    // explicit switch parks the thread
    logic sig;    // wake-up of another thread preempts
    logic instr;  // explicit / conditional switch instructions
    logic lazy;   // switch on use of a missed register
    logic now;    // switch at once on miss
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/mt_switch_pick.sv
module mt_switch_pick #(
  parameter int unsigned N_THREADS = 4,
  localparam int unsigned TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic [N_THREADS-1:0] req_i,
  output logic [TID_W-1:0]     idx_o,
  output logic                 found_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_THREADS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = TID_W'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/mt_switch_thread.sv
module mt_switch_thread
  import mt_switch_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter logic [MODE_W-1:0] MODE_RST = 5'b00101,
  parameter bit SLEEP_RST = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic             set_wait_i,
  input  logic             set_lazy_i,
  input  logic [REG_W-1:0] lazy_reg_i,
  input  logic             fill_i,
  input  logic             park_i,
  input  logic             wake_i,
  input  logic [REG_W-1:0] use_reg_i,
  output mode_t            mode_o,
  output logic             wait_o,
  output logic             asleep_o,
  output logic             lazy_hit_o
);
  mode_t            mode_q;
  logic             wait_q, asleep_q, lazy_vld_q;
  logic [REG_W-1:0] lazy_reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= mode_t'(MODE_RST);
      wait_q     <= 1'b0;
      asleep_q   <= SLEEP_RST;
      lazy_vld_q <= 1'b0;
      lazy_reg_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_t'(mode_i);

      if (set_wait_i)  wait_q <= 1'b1;
      else if (fill_i) wait_q <= 1'b0;

      if (set_lazy_i) begin
        lazy_vld_q <= 1'b1;
        lazy_reg_q <= lazy_reg_i;
      end else if (set_wait_i || fill_i) begin
        lazy_vld_q <= 1'b0;
      end

      if (wake_i)      asleep_q <= 1'b0;
      else if (park_i) asleep_q <= 1'b1;
    end
  end

  assign mode_o     = mode_q;
  assign wait_o     = wait_q;
  assign asleep_o   = asleep_q;
  assign lazy_hit_o = lazy_vld_q && (lazy_reg_q == use_reg_i);
endmodule

// File: rtl/mt_switch_ctrl.sv
module mt_switch_ctrl
  import mt_switch_pkg::*;
#(
  parameter int unsigned N_THREADS  = 4,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned SVC_THREAD = N_THREADS - 1,
  parameter logic [4:0]  MODE_RST   = 5'b00101,
  localparam int unsigned TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic [TID_W-1:0]     mode_tid_i,
  input  logic [4:0]           mode_i,
  input  logic                 miss_i,
  input  logic [REG_W-1:0]     miss_reg_i,
  input  logic                 use_i,
  input  logic [REG_W-1:0]     use_reg_i,
  input  logic                 sw_explicit_i,
  input  logic                 sw_cond_i,
  input  logic                 sw_cond_val_i,
  input  logic                 fill_i,
  input  logic [TID_W-1:0]     fill_tid_i,
  input  logic [N_THREADS-1:0] ext_sig_i,
  output logic [TID_W-1:0]     tid_o,
  output logic                 switch_o,
  output logic                 flush_o,
  output logic [TID_W-1:0]     flush_tid_o,
  output logic                 stall_o
);
  localparam logic [N_THREADS-1:0] ONE = N_THREADS'(1);

  logic [TID_W-1:0]     cur_q, ftid_q, nxt;
  logic                 sw_q, found;
  logic [N_THREADS-1:0] cur_oh, fill_oh, wait_v, asleep_v, lazy_hit_v, cand, idle_elig;
  mode_t                mode_v [N_THREADS];
  mode_t                cur_mode;
  logic                 use_hit, t_miss, t_use, t_ins, t_sig, trig, blocked_now, do_sw;
  logic                 set_lazy, park;

  assign cur_oh   = ONE << cur_q;
  assign fill_oh  = fill_i ? (ONE << fill_tid_i) : '0;
  assign cur_mode = mode_v[cur_q];

  // trigger decode for the running thread
  assign use_hit  = use_i && lazy_hit_v[cur_q];
  assign t_miss   = miss_i && cur_mode.now;
  assign t_use    = use_hit && cur_mode.lazy;
  assign t_ins    = cur_mode.instr && (sw_explicit_i || (sw_cond_i && sw_cond_val_i));
  assign t_sig    = cur_mode.sig && |(ext_sig_i & asleep_v & ~cur_oh);
  assign trig     = t_miss || t_use || t_ins || t_sig;
  assign set_lazy = miss_i && !cur_mode.now && cur_mode.lazy;
  assign park     = sw_explicit_i && cur_mode.instr && cur_mode.svc;

  // eligibility sees completions and wake-ups of this cycle
  assign blocked_now = |(cur_oh & ((wait_v & ~fill_oh) | (asleep_v & ~ext_sig_i)));
  assign cand        = (~wait_v | fill_oh) & (~asleep_v | ext_sig_i) & ~cur_oh;
  assign do_sw       = (trig || blocked_now) && found;

  mt_switch_pick #(.N_THREADS(N_THREADS)) u_pick (
    .req_i  (cand),
    .idx_o  (nxt),
    .found_o(found)
  );

  for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
    mt_switch_thread #(
      .REG_W    (REG_W),
      .MODE_RST (MODE_RST),
      .SLEEP_RST(g == SVC_THREAD)
    ) u_thr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_we_i (mode_we_i && (mode_tid_i == TID_W'(g))),
      .mode_i    (mode_i),
      .set_wait_i(cur_oh[g] && (t_miss || t_use)),
      .set_lazy_i(cur_oh[g] && set_lazy),
      .lazy_reg_i(miss_reg_i),
      .fill_i    (fill_oh[g]),
      .park_i    (cur_oh[g] && park),
      .wake_i    (ext_sig_i[g]),
      .use_reg_i (use_reg_i),
      .mode_o    (mode_v[g]),
      .wait_o    (wait_v[g]),
      .asleep_o  (asleep_v[g]),
      .lazy_hit_o(lazy_hit_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      sw_q   <= 1'b0;
      ftid_q <= '0;
    end else begin
      sw_q <= do_sw;
      if (do_sw) begin
        cur_q  <= nxt;
        ftid_q <= cur_q;
      end
    end
  end

  // stall from registered state only
  assign idle_elig = ~wait_v & ~asleep_v & ~cur_oh;
  assign stall_o   = |(cur_oh & (wait_v | asleep_v)) && !(|idle_elig);

  assign tid_o       = cur_q;
  assign switch_o    = sw_q;
  assign flush_o     = sw_q;
  assign flush_tid_o = ftid_q;
endmodule

// File: rtl/mt_switch_ctrl_chk.sv
module mt_switch_ctrl_chk #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned REG_W     = 5,
  localparam int unsigned TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 miss_i,
  input logic                 use_i,
  input logic                 sw_explicit_i,
  input logic                 sw_cond_i,
  input logic                 sw_cond_val_i,
  input logic                 fill_i,
  input logic [N_THREADS-1:0] ext_sig_i,
  input logic [TID_W-1:0]     tid_o,
  input logic                 switch_o,
  input logic                 flush_o,
  input logic [TID_W-1:0]     flush_tid_o,
  input logic                 stall_o
);
  a_r1_switch_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> $past(miss_i || use_i || sw_explicit_i || (sw_cond_i && sw_cond_val_i)
                       || (|ext_sig_i) || fill_i));

  a_r1_tid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !switch_o |-> $stable(tid_o));

  a_r9_tid_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> tid_o != $past(tid_o));

  a_r9_flush_old_tid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> flush_tid_o == $past(tid_o));

  a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !fill_i && !(|ext_sig_i)) |=> !switch_o);

  a_r8_tid_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tid_o) < N_THREADS);
endmodule

bind mt_switch_ctrl mt_switch_ctrl_chk #(.N_THREADS(N_THREADS), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_mt_switch_ctrl.sv
module tb_mt_switch_ctrl;
  localparam int unsigned N = 4;
  localparam int unsigned RW = 5;

  logic clk_i = 0, rst_ni = 0;
  logic mode_we_i = 0; logic [1:0] mode_tid_i = 0; logic [4:0] mode_i = 0;
  logic miss_i = 0; logic [RW-1:0] miss_reg_i = 0;
  logic use_i = 0; logic [RW-1:0] use_reg_i = 0;
  logic sw_explicit_i = 0, sw_cond_i = 0, sw_cond_val_i = 0;
  logic fill_i = 0; logic [1:0] fill_tid_i = 0;
  logic [N-1:0] ext_sig_i = 0;
  logic [1:0] tid_o, flush_tid_o;
  logic switch_o, flush_o, stall_o;

  mt_switch_ctrl #(.N_THREADS(N), .REG_W(RW)) dut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  typedef struct {
    logic       sw;
    logic [1:0] tid;
    logic [1:0] ftid;
    logic       stall;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  task automatic clr_in();
    mode_we_i = 0; miss_i = 0; use_i = 0; sw_explicit_i = 0;
    sw_cond_i = 0; sw_cond_val_i = 0; fill_i = 0; ext_sig_i = '0;
  endtask

  // driver: inputs already set at this negedge; push expectation, advance a cycle
  task automatic cyc(logic sw, logic [1:0] tid, logic [1:0] ftid, logic stall, string tag);
    exp_t e;
    e.sw = sw; e.tid = tid; e.ftid = ftid; e.stall = stall; e.tag = tag;
    sb.push_back(e);
    @(negedge clk_i);
    clr_in();
  endtask

  task automatic wr_mode(logic [1:0] t, logic [4:0] m);
    mode_we_i = 1; mode_tid_i = t; mode_i = m;
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk_i) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (switch_o !== e.sw || flush_o !== e.sw || tid_o !== e.tid || stall_o !== e.stall ||
          (e.sw && flush_tid_o !== e.ftid)) begin
        n_fail++;
        $display("FAIL %s: sw=%b flush=%b tid=%0d ftid=%0d stall=%b, expected sw=%b tid=%0d ftid=%0d stall=%b",
                 e.tag, switch_o, flush_o, tid_o, flush_tid_o, stall_o, e.sw, e.tid, e.ftid, e.stall);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;  // R10 reset state
    if (tid_o !== 0 || switch_o !== 0 || flush_o !== 0 || stall_o !== 0) begin
      n_fail++;
      $display("FAIL R10: tid=%0d sw=%b flush=%b stall=%b, expected 0 0 0 0",
               tid_o, switch_o, flush_o, stall_o);
    end
    rst_ni = 1;
    @(negedge clk_i);

    wr_mode(2'd3, 5'b10100);            cyc(0, 0, 0, 0, "R11 write t3 mode");
                                        cyc(0, 0, 0, 0, "R1 idle");
    miss_i = 1;                         cyc(1, 1, 0, 0, "R2 miss switch");
                                        cyc(0, 1, 0, 0, "R9 single pulse");
    sw_explicit_i = 1;                  cyc(1, 2, 1, 0, "R3 explicit");
    sw_cond_i = 1; sw_cond_val_i = 0;   cyc(0, 2, 0, 0, "R3 cond false");
    sw_cond_i = 1; sw_cond_val_i = 1;   cyc(1, 1, 2, 0, "R3 cond true skips waiting t0");
    fill_i = 1; fill_tid_i = 0;         cyc(0, 1, 0, 0, "R1 fill alone");
    sw_explicit_i = 1;                  cyc(1, 0, 1, 0, "R8 lowest index");
    wr_mode(2'd0, 5'b00000);            cyc(0, 0, 0, 0, "R11 disable t0");
    miss_i = 1;                         cyc(0, 0, 0, 0, "R5 miss ignored");
    sw_explicit_i = 1;                  cyc(0, 0, 0, 0, "R5 explicit ignored");
    wr_mode(2'd0, 5'b00110);            cyc(0, 0, 0, 0, "R11 lazy t0");
    miss_i = 1; miss_reg_i = 5;         cyc(0, 0, 0, 0, "R4 lazy miss no switch");
    use_i = 1; use_reg_i = 7;           cyc(0, 0, 0, 0, "R4 other reg");
    use_i = 1; use_reg_i = 5;           cyc(1, 1, 0, 0, "R4 use switch");
    sw_explicit_i = 1;                  cyc(1, 2, 1, 0, "R2 t0 still waiting");
    fill_i = 1; fill_tid_i = 0;         cyc(0, 2, 0, 0, "R1 fill t0");
    sw_explicit_i = 1;                  cyc(1, 0, 2, 0, "R8 back to t0");
    miss_i = 1; miss_reg_i = 9;         cyc(0, 0, 0, 0, "R4 lazy record");
    fill_i = 1; fill_tid_i = 0;         cyc(0, 0, 0, 0, "R4 early fill");
    use_i = 1; use_reg_i = 9;           cyc(0, 0, 0, 0, "R4 cancelled use");
    wr_mode(2'd0, 5'b01101);            cyc(0, 0, 0, 0, "R11 t0 sig");
    miss_i = 1;                         cyc(1, 1, 0, 0, "R2 miss t0");
    miss_i = 1;                         cyc(1, 2, 1, 0, "R2 miss t1");
    wr_mode(2'd2, 5'b01101);            cyc(0, 2, 0, 0, "R11 t2 sig");
    ext_sig_i = 4'b1000;                cyc(1, 3, 2, 0, "R6 wake preempts");
    sw_explicit_i = 1;                  cyc(1, 2, 3, 0, "R7 service parks");
    sw_explicit_i = 1;                  cyc(0, 2, 0, 0, "R8 R7 none eligible");
    miss_i = 1;                         cyc(0, 2, 0, 1, "R8 stall");
                                        cyc(0, 2, 0, 1, "R8 stall held");
    fill_i = 1; fill_tid_i = 1;         cyc(1, 1, 2, 0, "R8 fill ends stall");
    ext_sig_i = 4'b1000;                cyc(0, 1, 0, 0, "R5 R6 wake without sig mode");
    sw_explicit_i = 1;                  cyc(1, 3, 1, 0, "R6 woken thread chosen");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule